// File: doc/BRIEF.md
# Pin-Change Wake Detector

This block watches four pins of a six-bit digital port and asks the core to wake up when any of them moves away from the level that software last saw. Each time the port is read, the block stores a snapshot of the synchronized pin levels. While the core sleeps, the live synchronized levels are compared with that snapshot, and a mismatch on a watched pin raises the wake request. The comparison is made against the last read, not the previous clock. A change that software has not read therefore wakes the core at once on sleep entry.

One configuration register holds two active-low group controls. One enables wake-on-change and the other enables the weak pull-ups on the watched pins. A status flag records whether the most recent core reset was caused by a pin-change wake. The sequencer that turns the wake request into a reset lies outside this block. The analog pads also lie outside it.

Top module: `pin_change_wake`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block resets. Afterwards `wake_o` is 0, `wake_flag_o` is 0, `pullup_en_o` is all zeros, the snapshot is all zeros, and both configuration bits are 1 (wake disabled, pull-ups off).
- R2: Pin levels pass through a two-stage synchronizer. A pin change therefore shows in `wake_o` only after the second rising edge that follows it.
- R3: `wake_o` is 1 when three conditions all hold: `sleep_i` is 1, the stored wake-disable bit is 0, and a synchronized level on port bit 0, 1, 3 or 4 differs from the snapshot.
- R4: Changes on port bits 2 and 5 never raise `wake_o`.
- R5: While the stored wake-disable bit is 1, `wake_o` stays 0 whatever the pins do.
- R6: While `sleep_i` is 0, `wake_o` is 0.
- R7: Suppose a watched pin changed after the last port read and no read followed. When `sleep_i` then rises, `wake_o` is 1 in that same cycle, with no further pin change needed.
- R8: A high `rd_strobe` at a rising edge loads the synchronized pin levels into the snapshot. This clears a pending mismatch, so `wake_o` falls after that edge.
- R9: A high `cfg_wr` at a rising edge loads `cfg_wake_off` and `cfg_pull_off`. `pullup_en_o` is 6'b011011 while the stored pull-up bit is 0, and it is 6'b000000 while that bit is 1.
- R10: A high `core_rst` at a rising edge sets `wake_flag_o` to 1 if `wake_o` was 1 in that cycle, and to 0 otherwise. The same edge returns both configuration bits to 1. At all other times the flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pin_i | input | 6 | Asynchronous port pin levels |
| rd_strobe | input | 1 | Port read; captures the snapshot |
| sleep_i | input | 1 | Core is asleep |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wake_off | input | 1 | Wake-on-change control, active low (0 enables) |
| cfg_pull_off | input | 1 | Weak pull-up control, active low (0 enables) |
| core_rst | input | 1 | Non-power-on core reset event |
| wake_o | output | 1 | Wake request |
| pullup_en_o | output | 6 | Per-pin weak pull-up enables |
| wake_flag_o | output | 1 | Last core reset came from a pin-change wake |

## Verification
The bench goes after three cases in particular.

- **Change without a read before sleep.** A detector that compared against the previous clock would miss this case, and the core would never wake.
- **Change during sleep.** The bench counts the two synchronizer edges. A missing or extra stage shows up as wake rising one cycle early or late.
- **Disabled operation and the unwatched bits 2 and 5.** A wrong enable polarity or a full-width compare would raise wake where it must stay low.

The reset-cause flag is also checked in both directions. A flag that ignored the wake state, or that did not clear on a power-on reset, would report the wrong cause.

// File: rtl/pcw_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the pin-change wake detector.
// Assumes a six-bit port of which bits 0, 1, 3 and 4 are watched.
package pcw_pkg;
    localparam int PORT_W = 6;
    localparam logic [PORT_W-1:0] WATCH_MASK = 6'b011011;
    localparam int SYNC_STAGES = 2;

    // Configuration register; both bits active low controls, reset to 1.
    typedef struct packed {
        logic wake_off;
        logic pull_off;
    } pcw_cfg_t;
endpackage

// File: rtl/pcw_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent (no multi-bit coherency needed).
module pcw_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin levels one stage deeper each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else if (s == 0) stg[s] <= d_i;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcw_snapshot.sv
`timescale 1ns/1ps
// Holds the pin levels seen at the last port read and flags a mismatch
// on the watched bits. Assumes pin_s is already synchronous.
module pcw_snapshot #(
    parameter int              W     = 6,
    parameter logic [W-1:0]    WATCH = 6'b011011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_strobe,
    input  logic [W-1:0] pin_s,
    output logic         diff_o
);
    logic [W-1:0] snap;

    // Capture the synchronized levels on every port read.
    always_ff @(posedge clk) begin
        if (!rst_n)         snap <= '0;
        else if (rd_strobe) snap <= pin_s;
    end

    // Mismatch on any watched bit.
    always_comb begin
        diff_o = |((pin_s ^ snap) & WATCH);
    end

    // R8
    snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (snap == $past(pin_s)));

    // R8
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(snap));
endmodule

// File: rtl/pcw_cfg.sv
`timescale 1ns/1ps
// Configuration register (wake and pull-up controls, active low) and
// the reset-cause flag. Assumes core_rst is a one-cycle synchronous event.
module pcw_cfg
    import pcw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     core_rst,
    input  logic     cfg_wr,
    input  logic     cfg_wake_off,
    input  logic     cfg_pull_off,
    input  logic     wake_now,
    output pcw_cfg_t cfg_o,
    output logic     flag_o
);
    // Load configuration on write; any reset returns it to disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst) cfg_o <= '{wake_off: 1'b1, pull_off: 1'b1};
        else if (cfg_wr)        cfg_o <= '{wake_off: cfg_wake_off, pull_off: cfg_pull_off};
    end

    // Record whether the core reset was caused by a pending wake.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_o <= 1'b0;
        else if (core_rst) flag_o <= wake_now;
    end

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && wake_now) |=> flag_o);

    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && !wake_now) |=> !flag_o);

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst |=> $stable(flag_o));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !core_rst) |=> $stable(cfg_o));
endmodule

// File: rtl/pin_change_wake.sv
`timescale 1ns/1ps
// Pin-change wake detector top. Synchronizes the port pins, compares them
// with the snapshot from the last read, and requests wake while asleep.
// Assumes the reset sequencer acts on wake_o and pulses core_rst.
module pin_change_wake
    import pcw_pkg::*;
#(
    parameter int                  PORT_W_P = PORT_W,
    parameter logic [PORT_W_P-1:0] WATCH_P  = WATCH_MASK,
    parameter int                  SYNC_P   = SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PORT_W_P-1:0] pin_i,
    input  logic                rd_strobe,
    input  logic                sleep_i,
    input  logic                cfg_wr,
    input  logic                cfg_wake_off,
    input  logic                cfg_pull_off,
    input  logic                core_rst,
    output logic                wake_o,
    output logic [PORT_W_P-1:0] pullup_en_o,
    output logic                wake_flag_o
);
    logic [PORT_W_P-1:0] pin_s;
    logic                diff;
    pcw_cfg_t            cfg;

    pcw_sync #(.W(PORT_W_P), .STAGES(SYNC_P)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
    );

    pcw_snapshot #(.W(PORT_W_P), .WATCH(WATCH_P)) u_snap (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
        .pin_s(pin_s), .diff_o(diff)
    );

    pcw_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .core_rst(core_rst),
        .cfg_wr(cfg_wr), .cfg_wake_off(cfg_wake_off),
        .cfg_pull_off(cfg_pull_off), .wake_now(wake_o),
        .cfg_o(cfg), .flag_o(wake_flag_o)
    );

    // Wake request: asleep, enabled, and a watched pin moved since the read.
    always_comb begin
        wake_o = sleep_i && !cfg.wake_off && diff;
    end

    // Group-wide pull-up enable for the watched pins.
    always_comb begin
        pullup_en_o = cfg.pull_off ? '0 : WATCH_P;
    end

    // R6
    awake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |-> !wake_o);

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.wake_off |-> !wake_o);

    // R9
    pull_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pullup_en_o == '0) || (pullup_en_o == WATCH_P));
endmodule

// File: tb/sim_pin_change_wake.sv
`timescale 1ns/1ps
module sim_pin_change_wake;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pin_i = '0;
    logic       rd_strobe = 1'b0, sleep_i = 1'b0, cfg_wr = 1'b0;
    logic       cfg_wake_off = 1'b1, cfg_pull_off = 1'b1, core_rst = 1'b0;
    logic       wake_o, wake_flag_o;
    logic [5:0] pullup_en_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pin_change_wake u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rd_strobe(rd_strobe),
        .sleep_i(sleep_i), .cfg_wr(cfg_wr), .cfg_wake_off(cfg_wake_off),
        .cfg_pull_off(cfg_pull_off), .core_rst(core_rst), .wake_o(wake_o),
        .pullup_en_o(pullup_en_o), .wake_flag_o(wake_flag_o)
    );

    // {tag[3:0], pins[5:0], read, sleep, expected wake}
    localparam logic [12:0] VEC [13] = '{
        {4'd3, 6'b000000, 1'b1, 1'b1, 1'b0},
        {4'd7, 6'b000001, 1'b0, 1'b1, 1'b1},  // R7 change, no read
        {4'd8, 6'b000001, 1'b1, 1'b1, 1'b0},  // R8
        {4'd4, 6'b000101, 1'b0, 1'b1, 1'b0},  // R4 bit 2
        {4'd4, 6'b100101, 1'b0, 1'b1, 1'b0},  // R4 bit 5
        {4'd3, 6'b101101, 1'b0, 1'b1, 1'b1},  // R3 bit 3
        {4'd3, 6'b111101, 1'b0, 1'b1, 1'b1},
        {4'd8, 6'b111111, 1'b1, 1'b1, 1'b0},
        {4'd3, 6'b101111, 1'b0, 1'b1, 1'b1},  // R3 bit 4
        {4'd6, 6'b101111, 1'b0, 1'b0, 1'b0},  // R6 awake
        {4'd8, 6'b101101, 1'b1, 1'b1, 1'b0},
        {4'd3, 6'b101100, 1'b0, 1'b1, 1'b1},  // R3 bit 0
        {4'd3, 6'b101110, 1'b0, 1'b1, 1'b1}   // R3 bits 0,1
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic wk, logic pu);
        cfg_wr = 1'b1; cfg_wake_off = wk; cfg_pull_off = pu;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 wake", {7'd0, wake_o}, 8'd0);
        chk("R1 flag", {7'd0, wake_flag_o}, 8'd0);
        chk("R1 pullup", {2'd0, pullup_en_o}, 8'd0);

        // R9 pull-up off while wake enabled
        write_cfg(1'b0, 1'b1);
        chk("R9 pull off", {2'd0, pullup_en_o}, 8'd0);

        // Vector table walk
        for (int i = 0; i < 13; i++) begin
            pin_i = VEC[i][8:3]; sleep_i = 1'b0;
            repeat (3) tick();
            if (VEC[i][2]) begin
                rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
            end
            sleep_i = VEC[i][1];
            tick();
            chk($sformatf("R%0d vector %0d", VEC[i][12:9], i),
                {7'd0, wake_o}, {7'd0, VEC[i][0]});
        end
        // State: snapshot 101101, pins 101110 (mismatch on bits 0,1)

        // R5 disabled: mismatch present, asleep, no wake
        sleep_i = 1'b0;
        write_cfg(1'b1, 1'b1);
        sleep_i = 1'b1;
        tick();
        chk("R5 disabled", {7'd0, wake_o}, 8'd0);
        pin_i = 6'b100100; repeat (3) tick();
        chk("R5 disabled after change", {7'd0, wake_o}, 8'd0);
        pin_i = 6'b101110; repeat (3) tick();

        // R9 and R3: enable both
        write_cfg(1'b0, 1'b0);
        chk("R9 pull on", {2'd0, pullup_en_o}, 8'h1b);
        chk("R3 enabled", {7'd0, wake_o}, 8'd1);

        // R8 read while asleep clears request
        rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
        chk("R8 read clears", {7'd0, wake_o}, 8'd0);

        // R2 change during sleep: two edges of latency
        pin_i = 6'b101100;
        tick();
        chk("R2 one edge", {7'd0, wake_o}, 8'd0);
        tick();
        chk("R2 two edges", {7'd0, wake_o}, 8'd1);

        // R10 wake-caused core reset
        core_rst = 1'b1; tick(); core_rst = 1'b0;
        chk("R10 flag set", {7'd0, wake_flag_o}, 8'd1);
        chk("R10 cfg reverts", {2'd0, pullup_en_o}, 8'd0);
        chk("R10 wake off after reset", {7'd0, wake_o}, 8'd0);
        tick();
        chk("R10 flag holds", {7'd0, wake_flag_o}, 8'd1);
        core_rst = 1'b1; tick(); core_rst = 1'b0;
        chk("R10 flag clear", {7'd0, wake_flag_o}, 8'd0);

        // R1 power-on reset clears flag
        write_cfg(1'b0, 1'b0);
        core_rst = 1'b1; tick(); core_rst = 1'b0;
        chk("R10 flag set again", {7'd0, wake_flag_o}, 8'd1);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R1 flag after reset", {7'd0, wake_flag_o}, 8'd0);
        chk("R1 pullup after reset", {2'd0, pullup_en_o}, 8'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule